// File: doc/BRIEF.md
# Smart Card Receive Character FIFO

This block buffers characters coming out of a smart card receiver. Each time the receive shift register completes a character, it presents one 10-bit word together with a one-cycle write strobe. The low eight bits of the word are the data byte. The two upper bits are the parity-error flag and the framing-error flag for that byte. The FIFO holds 32 such words. A reader pops one word per read strobe, and each word comes back with its status bits still attached.

The write and read pointers are one bit wider than the address, so a full FIFO and an empty FIFO give different pointer states. Occupancy is the write pointer minus the read pointer, taken modulo twice the depth. The depth must be a power of two.

The block compares occupancy with a programmable threshold and raises a threshold flag. It also reports empty and full. A sticky overrun flag records any write that had to be dropped.

Top module: `sc_rx_char_fifo`

## Requirements
- R1: After reset, `empty`=1, `full`=0, `thr_hit`=0, `overrun`=0 and `rd_data`=0.
- R2: Words come out in the order they were written. All 10 bits come back unchanged: byte in [7:0], parity-error flag in bit 8, framing-error flag in bit 9. A read that pops a word places it on `rd_data` at the clock edge that samples the read strobe. `rd_data` keeps that value until the next read.
- R3: The FIFO holds 32 words. `empty` is high exactly when occupancy is 0, and `full` is high exactly when occupancy is 32. Both flags reflect the state after the latest clock edge.
- R4: A write strobe while the FIFO is full, with no read in the same cycle, is dropped. The stored words are not changed, and `overrun` is set.
- R5: `overrun` stays high until `ovr_clr` is sampled high. If a dropped write and `ovr_clr` occur in the same cycle, `overrun` stays set.
- R6: A read strobe while the FIFO is empty loads 0 into `rd_data` and does not move the read pointer.
- R7: A read and a write in the same cycle on a non-empty FIFO leave occupancy unchanged. This also holds when the FIFO is full: the write is accepted and `overrun` is not set.
- R8: `thr_hit` is high while `thresh` is non-zero and occupancy is greater than or equal to `thresh`. It drops as soon as reads bring occupancy below `thresh`.
- R9: When `thresh` is 0, `thr_hit` stays low at every occupancy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Character-complete write strobe |
| wr_data | input | 10 | {framing err, parity err, byte} |
| rd_en | input | 1 | Pop strobe |
| rd_data | output | 10 | Last popped word, or 0 after a read while empty |
| thresh | input | 6 | Receive-data threshold, 0 disables |
| ovr_clr | input | 1 | Clears the sticky overrun flag |
| empty | output | 1 | Occupancy is 0 |
| full | output | 1 | Occupancy is 32 |
| thr_hit | output | 1 | Occupancy is at or above a non-zero threshold |
| overrun | output | 1 | Sticky: a write was dropped |

## Verification
Every result is due one clock edge after the stimulus that causes it. A popped word, and the zero returned by a read while empty, appear on `rd_data` at the edge that samples the read strobe. The `empty`, `full`, `thr_hit` and `overrun` flags take their new values at that same edge.

The bench drives its inputs at the falling edge and updates its reference model right after the rising edge. The scoreboard monitor then compares both the popped word and every status flag at the following falling edge, half a cycle after the edge that produced them.

// File: rtl/sc_rx_char_fifo.sv
module sc_rx_char_fifo #(
  parameter int DEPTH  = 32,
  parameter int WORD_W = 10,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [WORD_W-1:0] rd_data,
  input  logic [PW-1:0]     thresh,
  input  logic              ovr_clr,
  output logic              empty,
  output logic              full,
  output logic              thr_hit,
  output logic              overrun
);

  localparam logic [PW-1:0] FULL_CNT = PW'(DEPTH);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [PW-1:0]     wptr, rptr, count;
  logic              rd_ok, wr_ok;

  // occupancy wraps modulo 2*DEPTH
  assign count   = wptr - rptr;
  assign empty   = (count == '0);
  assign full    = (count == FULL_CNT);
  assign thr_hit = (thresh != '0) && (count >= thresh);

  // a read on a full FIFO frees the slot a same-cycle write needs
  assign rd_ok = rd_en && !empty;
  assign wr_ok = wr_en && (!full || rd_ok);

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wptr[AW-1:0]] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr    <= '0;
      rptr    <= '0;
      rd_data <= '0;
      overrun <= 1'b0;
    end else begin
      if (wr_ok) wptr <= wptr + 1'b1;
      if (rd_ok) begin
        rptr    <= rptr + 1'b1;
        rd_data <= mem[rptr[AW-1:0]];
      end else if (rd_en) begin
        rd_data <= '0;
      end
      if (wr_en && !wr_ok) overrun <= 1'b1;
      else if (ovr_clr)    overrun <= 1'b0;
    end
  end

endmodule

// File: rtl/sc_rx_char_fifo_chk.sv
module sc_rx_char_fifo_chk #(
  parameter int WORD_W = 10,
  parameter int PW     = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic [WORD_W-1:0] rd_data,
  input logic [PW-1:0]     thresh,
  input logic              ovr_clr,
  input logic              empty,
  input logic              full,
  input logic              thr_hit,
  input logic              overrun
);

  AST_EMPTY_FULL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(empty && full)); // R3

  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    full && wr_en && !rd_en |=> full); // R4

  AST_OVR_ON_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    full && wr_en && !rd_en |=> overrun); // R4

  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overrun && !ovr_clr |=> overrun); // R5

  AST_OVR_NO_SELF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    !overrun && !(wr_en && full) |=> !overrun); // R5

  AST_RD_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && empty && !wr_en |=> (rd_data == '0) && empty); // R6

  AST_FULL_RW_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    full && wr_en && rd_en |=> full && $stable(overrun)); // R7

  AST_THR_ZERO_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (thresh == '0) |-> !thr_hit); // R9

  AST_THR_EMPTY_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !thr_hit); // R8

endmodule

bind sc_rx_char_fifo sc_rx_char_fifo_chk #(.WORD_W(WORD_W), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .rd_data(rd_data),
  .thresh(thresh), .ovr_clr(ovr_clr), .empty(empty), .full(full),
  .thr_hit(thr_hit), .overrun(overrun)
);

// File: tb/sim_sc_rx_char_fifo.sv
`timescale 1ns/1ps
module sim_sc_rx_char_fifo;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0, ovr_clr = 1'b0;
  logic [9:0] wr_data = '0;
  logic [5:0] thresh = '0;
  logic [9:0] rd_data;
  logic       empty, full, thr_hit, overrun;

  int checks = 0, fails = 0;
  logic [9:0] mdl[$];
  logic [9:0] sb[$];
  logic       m_ovr = 1'b0;
  logic       mon_on = 1'b0;
  string      cur_req = "R1";

  always #4 clk = ~clk;

  sc_rx_char_fifo u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(rd_data), .thresh(thresh), .ovr_clr(ovr_clr), .empty(empty),
    .full(full), .thr_hit(thr_hit), .overrun(overrun)
  );

  task automatic chk(input string req, input string what, input logic [9:0] act, input logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  // driver: applies one cycle of stimulus and pushes expected results
  task automatic cyc(input logic w, input logic [9:0] d, input logic r, input logic c);
    logic rd_ok, wr_ok;
    @(negedge clk);
    wr_en = w; wr_data = d; rd_en = r; ovr_clr = c;
    @(posedge clk);
    rd_ok = r && (mdl.size() > 0);
    wr_ok = w && (mdl.size() < 32 || rd_ok);
    if (r) sb.push_back(rd_ok ? mdl.pop_front() : 10'h000);
    if (wr_ok) mdl.push_back(d);
    if (w && !wr_ok) m_ovr = 1'b1;
    else if (c) m_ovr = 1'b0;
    #1;
    wr_en = 1'b0; rd_en = 1'b0; ovr_clr = 1'b0;
  endtask

  // monitor: compares popped words and status half a cycle after each edge
  always @(negedge clk) begin
    if (mon_on) begin
      if (sb.size() > 0) chk({cur_req, "/R2"}, "rd_data", rd_data, sb.pop_front());
      chk({cur_req, "/R3"}, "empty", {9'b0, empty}, {9'b0, mdl.size() == 0});
      chk({cur_req, "/R3"}, "full", {9'b0, full}, {9'b0, mdl.size() == 32});
      chk({cur_req, "/R5"}, "overrun", {9'b0, overrun}, {9'b0, m_ovr});
      chk({cur_req, "/R8"}, "thr_hit", {9'b0, thr_hit},
          {9'b0, (thresh != 0) && (mdl.size() >= int'(thresh))});
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1", "empty", {9'b0, empty}, 10'h001);
    chk("R1", "full", {9'b0, full}, 10'h000);
    chk("R1", "thr_hit", {9'b0, thr_hit}, 10'h000);
    chk("R1", "overrun", {9'b0, overrun}, 10'h000);
    chk("R1", "rd_data", rd_data, 10'h000);
    @(negedge clk); rst_n = 1'b1; mon_on = 1'b1;

    cur_req = "R2";
    cyc(1, 10'h03B, 0, 0);
    cyc(1, 10'h1A5, 0, 0);
    cyc(1, 10'h25A, 0, 0);
    cyc(1, 10'h3FF, 0, 0);
    cyc(1, 10'h000, 0, 0);
    for (int i = 0; i < 5; i++) cyc(0, 0, 1, 0);

    cur_req = "R6";
    cyc(0, 0, 1, 0);
    cyc(0, 0, 1, 0);
    cyc(1, 10'h2C3, 0, 0);
    cyc(0, 0, 1, 0);
    cyc(1, 10'h111, 1, 0); // empty: read returns 0, write lands
    cyc(0, 0, 1, 0);

    cur_req = "R8";
    thresh = 6'd4;
    for (int i = 0; i < 6; i++) cyc(1, 10'(i * 37 + 5), 0, 0);
    for (int i = 0; i < 6; i++) cyc(0, 0, 1, 0);

    cur_req = "R3";
    thresh = 6'd32;
    for (int i = 0; i < 32; i++) cyc(1, 10'(i * 29 + 300), 0, 0);

    cur_req = "R4";
    cyc(1, 10'h3AA, 0, 0);
    cyc(1, 10'h155, 0, 0);

    cur_req = "R5";
    cyc(0, 0, 0, 0);
    cyc(1, 10'h0F0, 0, 1); // drop and clear together: stays set
    cyc(0, 0, 0, 1);
    cyc(0, 0, 0, 0);

    cur_req = "R7";
    cyc(1, 10'h2EE, 1, 0);
    cyc(1, 10'h1DD, 1, 0);

    cur_req = "R9";
    thresh = 6'd0;
    cyc(0, 0, 0, 0);
    for (int i = 0; i < 32; i++) cyc(0, 0, 1, 0);
    cyc(0, 0, 1, 0);
    cyc(0, 0, 0, 0);

    mon_on = 1'b0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule